// File: doc/BRIEF.md
# I/O Port Register Access Unit

This block is the slave side of an 8-bit I/O bus for a DMA-style peripheral. The CPU drives active-low chip-select, I/O-request, read and write strobes that have no timing relation to the block's clock. The block passes the strobes through a two-flop synchroniser and accepts an access only after the strobes have stayed the same across enough rising clock edges. A write stores the byte on the data input into one entry of a small write-register file. A read puts the contents of one of seven status registers on the read-data output for as long as the read strobes stay asserted. An external pad cell drives the shared bus from `rdata` when `rdata_oe` is high and floats it when `rdata_oe` is low.

The bus has fixed strobe timing, so the data paths use no valid/ready handshake and there is no back-pressure: the CPU holds the strobes long enough, and the block follows them. A 3-bit read pointer picks the status register to return. The pointer advances after each completed read and wraps from 6 to 0, and the `sel_load` input can reload it. An access that asserts read and write together is dropped and raised as a one-cycle protocol error.

Top module: `ioreg_port`

## Requirements
- R1: When chip select, I/O request and write are low and read is high, `din` is stored into write register `wsel` on the 4th rising edge after the strobes are applied. The register is unchanged after the 3rd edge. Register k occupies `wreg_out[8k+7:8k]`.
- R2: One write cycle stores exactly one byte. Changing `din` while the strobes stay held has no effect. A further write needs the strobes to be released first.
- R3: When chip select, I/O request and read are low and write is high, `rdata_oe` rises on the 5th rising edge after the strobes are applied, because the strobes must be seen unchanged across two edges. It is still low after the 4th edge.
- R4: `rdata` carries the status register selected by the pointer, captured when the read qualifies. It holds that value while the read lasts, even if `stat_in` changes. Status register k occupies `stat_in[8k+7:8k]`.
- R5: After any read strobe is released, `rdata_oe` stays high through the 1st rising edge and falls on the 2nd. `rdata` is zero whenever `rdata_oe` is low.
- R6: A read strobe held for only two rising edges never raises `rdata_oe` and does not move the pointer.
- R7: The pointer advances by one after each completed read and wraps from 6 to 0.
- R8: A one-cycle `sel_load` loads `sel_val` into the pointer at the next edge. A value of 7 loads 0. A load takes priority over an advance.
- R9: If read and write are both asserted with chip select and I/O request, `proto_err` is high for exactly one cycle, after the 3rd rising edge. Neither a write nor a read takes place.
- R10: A synchronous active-high `rst` clears the write registers, sets the pointer to 0 and holds `rdata_oe`, `rdata` and `proto_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| iorq_n | input | 1 | I/O request, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| din | input | DW | Write data from the bus |
| wsel | input | WSEL_W | Index of the write register that a write targets |
| sel_load | input | 1 | Load the read pointer from `sel_val` |
| sel_val | input | PTR_W | Value loaded into the read pointer |
| stat_in | input | NUM_RREG*DW | Contents of the seven status registers |
| rdata | output | DW | Read data for the bus pad cell |
| rdata_oe | output | 1 | Output enable for the bus pad cell |
| proto_err | output | 1 | One-cycle pulse when read and write collide |
| wreg_out | output | NUM_WREG*DW | Contents of the write registers |

## Verification
Every strobe change is applied 1 ns after a rising edge. Counting from that point, a write becomes visible after the 4th edge, the read enable after the 5th, the enable drop after the 2nd edge following release, and the collision pulse after the 3rd. A pointer load takes effect after one edge. Each directed task samples 1 ns after the edge where a result is due. It also samples after the edge just before, where the old value must still be present, so an early result and a late result both show up as mismatches. The bench keeps its own copy of the expected pointer and register contents, and works them out from the requirements alone.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  // Internal strobe bundle, active-high after inversion of the bus pins
  typedef struct packed {
    logic cs;
    logic iorq;
    logic rd;
    logic wr;
  } strb_t;

  localparam int STRB_W = $bits(strb_t);
endpackage

// File: rtl/ioreg_sync.sv
module ioreg_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ioreg_qual.sv
module ioreg_qual
  import ioreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  strb_t s,
  output logic  wr_fire,
  output logic  rd_start,
  output logic  rd_act,
  output logic  clash_pulse
);
  strb_t      prev_q;
  logic [1:0] stab_cnt;
  logic       wr_done;
  logic       clash_q;

  logic sel_now, sel_prev, wr_act, clash_now, clash_prev, changed;

  assign sel_now    = s.cs & s.iorq;
  assign sel_prev   = prev_q.cs & prev_q.iorq;
  assign rd_act     = sel_now & s.rd & ~s.wr;
  assign wr_act     = sel_now & s.wr & ~s.rd;
  assign clash_now  = sel_now & s.rd & s.wr;
  assign clash_prev = sel_prev & prev_q.rd & prev_q.wr;
  assign changed    = (s != prev_q);

  // write: first edge at which the strobes equal the previous sample
  assign wr_fire  = wr_act & ~changed & (stab_cnt == 2'd0) & ~wr_done;
  // read: second such edge in a row
  assign rd_start = rd_act & ~changed & (stab_cnt == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      stab_cnt <= '0;
      wr_done  <= 1'b0;
      clash_q  <= 1'b0;
    end else begin
      prev_q <= s;
      if (changed)
        stab_cnt <= '0;
      else if (stab_cnt != 2'd2)
        stab_cnt <= stab_cnt + 2'd1;
      wr_done <= wr_act & (wr_done | wr_fire);
      clash_q <= clash_now & ~clash_prev;
    end
  end

  assign clash_pulse = clash_q;
endmodule

// File: rtl/ioreg_wfile.sv
module ioreg_wfile #(
  parameter int DW       = 8,
  parameter int NUM_WREG = 4,
  localparam int WSEL_W  = $clog2(NUM_WREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fire,
  input  logic [WSEL_W-1:0]      sel,
  input  logic [DW-1:0]          din,
  output logic [NUM_WREG*DW-1:0] regs
);
  for (genvar i = 0; i < NUM_WREG; i++) begin : g_wreg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)
        r_q <= '0;
      else if (fire && (sel == WSEL_W'(i)))
        r_q <= din;
    end
    assign regs[i*DW +: DW] = r_q;
  end
endmodule

// File: rtl/ioreg_rport.sv
module ioreg_rport #(
  parameter int DW       = 8,
  parameter int NUM_RREG = 7,
  localparam int PTR_W   = $clog2(NUM_RREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_start,
  input  logic                   rd_act,
  input  logic                   sel_load,
  input  logic [PTR_W-1:0]       sel_val,
  input  logic [NUM_RREG*DW-1:0] stat_in,
  output logic [DW-1:0]          rdata,
  output logic                   rdata_oe,
  output logic [PTR_W-1:0]       ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_RREG - 1);

  logic [DW-1:0]    stat_arr [NUM_RREG];
  logic [PTR_W-1:0] ptr_q;
  logic             busy_q;
  logic [DW-1:0]    data_q;
  logic             rd_end;

  for (genvar k = 0; k < NUM_RREG; k++) begin : g_stat
    assign stat_arr[k] = stat_in[k*DW +: DW];
  end

  assign rd_end = busy_q & ~rd_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      data_q <= '0;
    end else if (rd_start) begin
      busy_q <= 1'b1;
      data_q <= stat_arr[ptr_q];
    end else if (rd_end) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (sel_load)
      ptr_q <= (sel_val > LAST) ? '0 : sel_val;
    else if (rd_end)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign rdata_oe = busy_q & rd_act;
  assign rdata    = rdata_oe ? data_q : '0;
  assign ptr      = ptr_q;
endmodule

// File: rtl/ioreg_port.sv
module ioreg_port
  import ioreg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NUM_WREG = 4,
  parameter int NUM_RREG = 7,
  localparam int WSEL_W  = $clog2(NUM_WREG),
  localparam int PTR_W   = $clog2(NUM_RREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   iorq_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [DW-1:0]          din,
  input  logic [WSEL_W-1:0]      wsel,
  input  logic                   sel_load,
  input  logic [PTR_W-1:0]       sel_val,
  input  logic [NUM_RREG*DW-1:0] stat_in,
  output logic [DW-1:0]          rdata,
  output logic                   rdata_oe,
  output logic                   proto_err,
  output logic [NUM_WREG*DW-1:0] wreg_out
);
  strb_t            raw_s;
  strb_t            sync_s;
  logic             wr_fire, rd_start, rd_act;
  logic [PTR_W-1:0] rptr;

  assign raw_s = '{cs: ~cs_n, iorq: ~iorq_n, rd: ~rd_n, wr: ~wr_n};

  ioreg_sync #(.W(STRB_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_s),
    .q   (sync_s)
  );

  ioreg_qual u_qual (
    .clk         (clk),
    .rst         (rst),
    .s           (sync_s),
    .wr_fire     (wr_fire),
    .rd_start    (rd_start),
    .rd_act      (rd_act),
    .clash_pulse (proto_err)
  );

  ioreg_wfile #(.DW(DW), .NUM_WREG(NUM_WREG)) u_wfile (
    .clk  (clk),
    .rst  (rst),
    .fire (wr_fire),
    .sel  (wsel),
    .din  (din),
    .regs (wreg_out)
  );

  ioreg_rport #(.DW(DW), .NUM_RREG(NUM_RREG)) u_rport (
    .clk      (clk),
    .rst      (rst),
    .rd_start (rd_start),
    .rd_act   (rd_act),
    .sel_load (sel_load),
    .sel_val  (sel_val),
    .stat_in  (stat_in),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .ptr      (rptr)
  );
endmodule

// File: rtl/ioreg_port_chk.sv
module ioreg_port_chk #(
  parameter int DW       = 8,
  parameter int NUM_WREG = 4,
  parameter int NUM_RREG = 7,
  localparam int PTR_W   = $clog2(NUM_RREG)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cs_n,
  input logic                   iorq_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic                   sel_load,
  input logic [DW-1:0]          rdata,
  input logic                   rdata_oe,
  input logic                   proto_err,
  input logic [NUM_WREG*DW-1:0] wreg_out,
  input logic [PTR_W-1:0]       rptr
);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err);

  // R5
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == '0));

  // R3
  rd_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> ($past(!cs_n && !iorq_n && !rd_n && wr_n, 1) &&
                         $past(!cs_n && !iorq_n && !rd_n && wr_n, 4)));

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(!cs_n && !iorq_n && !rd_n, 2));

  // R1
  wreg_chg_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wreg_out) |-> $past(!cs_n && !iorq_n && !wr_n && rd_n, 2));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rptr <= PTR_W'(NUM_RREG - 1));

  // R8
  ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rptr) |-> ($past(sel_load) || $past(rdata_oe, 2)));
endmodule

bind ioreg_port ioreg_port_chk #(
  .DW(DW), .NUM_WREG(NUM_WREG), .NUM_RREG(NUM_RREG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .iorq_n    (iorq_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .sel_load  (sel_load),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe),
  .proto_err (proto_err),
  .wreg_out  (wreg_out),
  .rptr      (rptr)
);

// File: tb/ioreg_port_tb.sv
`timescale 1ns/1ps
module ioreg_port_tb;
  localparam int DW = 8, NW = 4, NR = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [1:0] wsel = '0;
  logic sel_load = 1'b0;
  logic [2:0] sel_val = '0;
  logic [NR*DW-1:0] stat_in;
  logic [DW-1:0] rdata;
  logic rdata_oe, proto_err;
  logic [NW*DW-1:0] wreg_out;

  int n_chk = 0, n_bad = 0;
  int exp_ptr = 0;
  logic [DW-1:0] exp_w [NW];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ioreg_port u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .wsel(wsel), .sel_load(sel_load),
    .sel_val(sel_val), .stat_in(stat_in), .rdata(rdata),
    .rdata_oe(rdata_oe), .proto_err(proto_err), .wreg_out(wreg_out)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stat(input logic [DW-1:0] base);
    for (int k = 0; k < NR; k++) stat_in[k*DW +: DW] = base + DW'(k);
  endtask

  task automatic idle();
    cs_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3); rst = 1'b0; step(1);
    check("R10 oe", rdata_oe, 0);
    check("R10 rdata", rdata, 0);
    check("R10 err", proto_err, 0);
    check("R10 wregs", wreg_out, 0);
    for (int k = 0; k < NW; k++) exp_w[k] = '0;
  endtask

  task automatic t_write(input int idx, input logic [DW-1:0] val);
    wsel = 2'(idx); din = val;
    cs_n = 1'b0; iorq_n = 1'b0; wr_n = 1'b0;
    step(3);
    check("R1 before 4th edge", wreg_out[idx*DW +: DW], exp_w[idx]);
    step(1);
    exp_w[idx] = val;
    check("R1 latched", wreg_out[idx*DW +: DW], val);
    idle(); step(3);
  endtask

  task automatic t_write_hold();
    wsel = 2'd2; din = 8'h5A;
    cs_n = 1'b0; iorq_n = 1'b0; wr_n = 1'b0;
    step(4);
    exp_w[2] = 8'h5A;
    check("R2 first byte", wreg_out[2*DW +: DW], 8'h5A);
    din = 8'hFF; step(6);
    check("R2 held strobes ignore din", wreg_out[2*DW +: DW], 8'h5A);
    idle(); step(3);
    t_write(2, 8'h3C); // R2 new write after release
  endtask

  task automatic t_read(input string req);
    logic [DW-1:0] e;
    e = stat_in[exp_ptr*DW +: DW];
    cs_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0;
    step(4);
    check("R3 oe low at 4th edge", rdata_oe, 0);
    step(1);
    check("R3 oe high at 5th edge", rdata_oe, 1);
    check(req, rdata, e);
    idle(); step(1);
    check("R5 oe held 1st edge", rdata_oe, 1);
    step(1);
    check("R5 oe dropped", rdata_oe, 0);
    check("R5 rdata zero", rdata, 0);
    step(3);
    exp_ptr = (exp_ptr == NR - 1) ? 0 : exp_ptr + 1;
  endtask

  task automatic t_snapshot();
    logic [DW-1:0] e;
    e = stat_in[exp_ptr*DW +: DW];
    cs_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0;
    step(5);
    set_stat(8'hC0); step(3);
    check("R4 data held during read", rdata, e);
    idle(); step(5);
    set_stat(8'hA0);
    exp_ptr = (exp_ptr == NR - 1) ? 0 : exp_ptr + 1;
  endtask

  task automatic t_load(input logic [2:0] v, input int expect_ptr);
    sel_load = 1'b1; sel_val = v; step(1); sel_load = 1'b0;
    exp_ptr = expect_ptr;
    t_read("R8 read after load");
  endtask

  task automatic t_short_read();
    cs_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0;
    step(2);
    idle();
    for (int k = 0; k < 6; k++) begin
      step(1);
      check("R6 short read no oe", rdata_oe, 0);
    end
    t_read("R6 pointer not moved");
  endtask

  task automatic t_conflict();
    wsel = 2'd1; din = 8'hEE;
    cs_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    step(2);
    check("R9 err low at 2nd edge", proto_err, 0);
    step(1);
    check("R9 err at 3rd edge", proto_err, 1);
    step(1);
    check("R9 err one cycle", proto_err, 0);
    step(4);
    check("R9 no read", rdata_oe, 0);
    check("R9 no write", wreg_out[1*DW +: DW], exp_w[1]);
    idle(); step(3);
    t_read("R9 pointer unchanged");
  endtask

  initial begin
    set_stat(8'hA0);
    t_reset();
    t_write(0, 8'h11);
    t_write(1, 8'h22);
    t_write(3, 8'h44);
    t_write_hold();
    for (int k = 0; k < NR; k++) t_read("R4 data from pointer, R7 advance");
    t_read("R7 wrap 6 to 0");
    t_snapshot();
    t_load(3'd4, 4);
    t_load(3'd7, 0);
    t_short_read();
    t_conflict();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule